// File: doc/BRIEF.md
# Break-Event Trigger Pulse Unit

This block turns break events from two independent comparator channels into a single pulse on one active-high trigger pin. Each channel supplies a one-cycle "break satisfied" strobe and a separate one-cycle "bus cycle matched" strobe. A per-channel mask bit chooses whether that channel's breaks reach the pin. A two-bit selector sets the pulse length to 1, 2, 4 or 8 clock cycles. The pin is driven from a register, so it is free of glitches.

Each channel also has a sticky match flag. The channel's bus-match strobe sets the flag. The flag clears only when software writes 0 to its bit. All control bits and flags live in one 32-bit word, which software writes through `wr_en`/`wr_data` and reads back on `rd_data`.

The pulse timing comes from a two-state machine:
- In `ST_IDLE`, an unmasked break takes the START transition into `ST_PULSE`. The down-counter is loaded with the programmed length minus one.
- In `ST_PULSE`, another unmasked break takes RESTART, which reloads the full length.
- In `ST_PULSE` with no break and a non-zero count, the machine takes HOLD and decrements the counter.
- In `ST_PULSE` with no break and a count of zero, the machine takes DONE back to `ST_IDLE`.

Top module: `brk_trig_unit`

## Requirements
- R1: After reset, `trig_out` is 0 and `rd_data` reads 0. This covers both mask bits, the width selector and both flags.
- R2: An unmasked break strobe sampled at clock edge k makes `trig_out` high in the cycle that starts at edge k.
- R3: The pulse length follows word bits 17:16. 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: Bit 18 masks channel 0 and bit 19 masks channel 1. A break on a masked channel produces no pulse. An unmasked channel still pulses normally.
- R5: A bus-match strobe sets the channel's flag (bit 15 for channel 0, bit 14 for channel 1). The flag then stays set.
- R6: A write with a flag's bit at 0 clears that flag. A write with the bit at 1 leaves the flag unchanged.
- R7: If a bus-match strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: An unmasked break that arrives during a pulse restarts the count at the full programmed length.
- R9: Breaks on both unmasked channels in the same cycle produce one pulse of the programmed length.
- R10: Changing the width selector during a pulse leaves that pulse's length unchanged. Only later pulses use the new length.
- R11: Bits 19:16 read back as written. All bits outside 19:14 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_ev | input | 2 | Per-channel one-cycle break-satisfied strobe |
| bus_match | input | 2 | Per-channel one-cycle bus-cycle-match strobe |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| trig_out | output | 1 | Registered trigger pulse pin |

## Verification
The assertions assume that `brk_ev` and `bus_match` are synchronous to `clk` and are sampled only at rising edges. They also assume that a write is a single-cycle `wr_en` pulse with stable data. The bench changes every input on the falling edge, so each strobe is seen by exactly one rising edge. It samples `trig_out` and `rd_data` on the next falling edge. Writes to the control word set the flag bits to 1 unless the test means to clear a flag, so a configuration change cannot disturb flag state by accident.

// File: rtl/brk_trig_pkg.sv
package brk_trig_pkg;
    localparam int CH_N   = 2;
    localparam int SEL_W  = 2;
    localparam int DATA_W = 32;
    // word layout: mask bits rise from channel 0, flag bits fall from channel 0
    localparam int POS_MASK0 = 18;
    localparam int POS_SEL   = 16;
    localparam int POS_FLAG0 = 15;

    typedef enum logic {ST_IDLE, ST_PULSE} pulse_st_t;
endpackage

// File: rtl/brk_trig_regs.sv
module brk_trig_regs
    import brk_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   bus_match,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CH_N-1:0]   ch_mask,
    output logic [SEL_W-1:0]  width_sel
);
    logic [CH_N-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_mask   <= '0;
            width_sel <= '0;
        end else if (wr_en) begin
            width_sel <= wr_data[POS_SEL +: SEL_W];
            for (int c = 0; c < CH_N; c++) ch_mask[c] <= wr_data[POS_MASK0 + c];
        end
    end

    for (genvar g = 0; g < CH_N; g++) begin : g_flag
        localparam int FPOS = POS_FLAG0 - g;
        logic keep;
        always_comb keep = flag_q[g] & ~(wr_en & ~wr_data[FPOS]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= bus_match[g] | keep;
        end

        // R5 R7
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_match[g] |=> flag_q[g]);
        // R5
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[g]) |-> $past(bus_match[g]));
        // R6
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !(wr_en && !wr_data[FPOS])) |=> flag_q[g]);
    end

    always_comb begin
        rd_data = '0;
        rd_data[POS_SEL +: SEL_W] = width_sel;
        for (int c = 0; c < CH_N; c++) begin
            rd_data[POS_MASK0 + c] = ch_mask[c];
            rd_data[POS_FLAG0 - c] = flag_q[c];
        end
    end
endmodule

// File: rtl/brk_trig_fsm.sv
module brk_trig_fsm
    import brk_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  brk_ev,
    input  logic [CH_N-1:0]  ch_mask,
    input  logic [SEL_W-1:0] width_sel,
    output logic             trig_out
);
    localparam int MAX_LEN = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN);

    pulse_st_t        state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W:0]   len;
    logic [CNT_W:0]   len_m1;
    logic             fire;

    always_comb begin
        fire   = |(brk_ev & ~ch_mask);
        len    = (CNT_W+1)'(1) << width_sel;
        len_m1 = len - (CNT_W+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (fire) begin                 // START
                    nxt_state = ST_PULSE;
                    nxt_cnt   = len_m1[CNT_W-1:0];
                end
            end
            ST_PULSE: begin
                if (fire) begin                 // RESTART
                    nxt_cnt = len_m1[CNT_W-1:0];
                end else if (cnt == '0) begin   // DONE
                    nxt_state = ST_IDLE;
                end else begin                  // HOLD
                    nxt_cnt = cnt - CNT_W'(1);
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_comb trig_out = (state == ST_PULSE);

    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trig_out);
    // R2 R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(fire));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_out && !fire) |=> !trig_out);
endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
    import brk_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   brk_ev,
    input  logic [CH_N-1:0]   bus_match,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              trig_out
);
    logic [CH_N-1:0]  ch_mask;
    logic [SEL_W-1:0] width_sel;

    brk_trig_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_match (bus_match),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ch_mask   (ch_mask),
        .width_sel (width_sel)
    );

    brk_trig_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_ev    (brk_ev),
        .ch_mask   (ch_mask),
        .width_sel (width_sel),
        .trig_out  (trig_out)
    );

    // R11
    rd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:20] == '0) && (rd_data[13:0] == '0));
endmodule

// File: tb/brk_trig_unit_tb.sv
module brk_trig_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  brk_ev = '0;
    logic [1:0]  bus_match = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        trig_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    brk_trig_unit u_dut (
        .clk(clk), .rst_n(rst_n), .brk_ev(brk_ev), .bus_match(bus_match),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .trig_out(trig_out)
    );

    // entry: {sel[1:0], mask[1:0], brk[1:0], expected length[3:0]}
    localparam logic [9:0] VEC [11] = '{
        {2'b00, 2'b00, 2'b01, 4'd1},
        {2'b01, 2'b00, 2'b10, 4'd2},
        {2'b10, 2'b00, 2'b01, 4'd4},
        {2'b11, 2'b00, 2'b10, 4'd8},
        {2'b10, 2'b01, 2'b01, 4'd0},
        {2'b10, 2'b01, 2'b10, 4'd4},
        {2'b01, 2'b10, 2'b10, 4'd0},
        {2'b01, 2'b10, 2'b01, 4'd2},
        {2'b11, 2'b11, 2'b11, 4'd0},
        {2'b10, 2'b00, 2'b11, 4'd4},
        {2'b00, 2'b11, 2'b01, 4'd0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // strobe breaks, then count the high cycles of the pulse
    task automatic pulse_len(logic [1:0] b, output int len);
        @(negedge clk);
        brk_ev = b;
        @(negedge clk);
        brk_ev = '0;
        len = 0;
        while (trig_out && len < 40) begin
            len++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] cfg(logic [1:0] sel, logic [1:0] msk);
        return {12'd0, msk[1], msk[0], sel, 2'b11, 14'd0};
    endfunction

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 trig_out", {31'd0, trig_out}, 32'h0);

        // R11 read-back and unused bits
        write_word(32'hFFFF_FFFF);
        @(negedge clk);
        check("R11 readback all-ones", rd_data, 32'h000F_0000);
        write_word(32'h0000_C000);
        check("R11 readback restore", rd_data, 32'h0);

        // R3 R4 R9 table
        for (int i = 0; i < 11; i++) begin
            write_word(cfg(VEC[i][9:8], VEC[i][7:6]));
            pulse_len(VEC[i][5:4], len);
            check($sformatf("R3/R4/R9 vector %0d", i), len, {28'd0, VEC[i][3:0]});
        end

        // R2 pulse starts right after the strobe edge
        write_word(cfg(2'b00, 2'b00));
        @(negedge clk);
        brk_ev = 2'b01;
        check("R2 low during strobe", {31'd0, trig_out}, 32'h0);
        @(negedge clk);
        brk_ev = '0;
        check("R2 high next cycle", {31'd0, trig_out}, 32'h1);
        @(negedge clk);
        check("R2 one cycle", {31'd0, trig_out}, 32'h0);

        // R8 restart at full length: 3 cycles then 8 more
        write_word(cfg(2'b11, 2'b00));
        @(negedge clk);
        brk_ev = 2'b10;
        @(negedge clk);
        brk_ev = '0;
        len = 0;
        for (int k = 0; k < 3; k++) begin
            if (trig_out) len++;
            if (k == 2) brk_ev = 2'b01;
            @(negedge clk);
        end
        brk_ev = '0;
        while (trig_out && len < 40) begin
            len++;
            @(negedge clk);
        end
        check("R8 restarted length", len, 11);

        // R10 selector change during pulse
        @(negedge clk);
        brk_ev = 2'b01;
        @(negedge clk);
        brk_ev = '0;
        wr_en = 1'b1; wr_data = cfg(2'b00, 2'b00);
        len = 1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        while (trig_out && len < 40) begin
            len++;
            @(negedge clk);
        end
        check("R10 running pulse keeps 8", len, 8);
        pulse_len(2'b01, len);
        check("R10 later pulse uses 1", len, 1);

        // R5 sticky flags
        write_word(32'h0);
        @(negedge clk);
        bus_match = 2'b10;
        @(negedge clk);
        bus_match = '0;
        check("R5 ch1 flag bit14", rd_data, 32'h0000_4000);
        repeat (4) @(negedge clk);
        check("R5 flag sticky", rd_data, 32'h0000_4000);
        bus_match = 2'b01;
        @(negedge clk);
        bus_match = '0;
        check("R5 ch0 flag bit15", rd_data, 32'h0000_C000);

        // R6 write 1 keeps, write 0 clears
        write_word(32'h0000_C000);
        check("R6 write ones keep", rd_data, 32'h0000_C000);
        write_word(32'h0000_8000);
        check("R6 clear ch1 only", rd_data, 32'h0000_8000);

        // R7 set beats clear on ch0; ch1 set again, then cleared alone
        bus_match = 2'b10;
        @(negedge clk);
        bus_match = 2'b01;
        wr_en = 1'b1; wr_data = 32'h0;
        @(negedge clk);
        bus_match = '0; wr_en = 1'b0;
        check("R7 set wins, other cleared", rd_data, 32'h0000_8000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule